// File: doc/BRIEF.md
# Mains Home-Control Command Transmitter

This block sends one home-control command over the mains as carrier bursts that are timed to the zero crossings of the line voltage. A command is a house code, a key code and a repeat count, and it arrives through a valid/ready port. The block first locks onto the crossings. It then lets three full mains cycles pass with the carrier off. After that it sends the frame as many times as the repeat count asks, with no idle half-cycles between copies. It drives a carrier-enable line for an external modem, and it finishes with a one-cycle done pulse or a one-cycle error pulse with an error kind.

Each frame has 22 half-cycle slots. Four start slots come first. The 9 code bits follow, and each code bit takes two slots, true then inverted. A crossing opens every slot, and a slot that carries a 1 holds the carrier on for a fixed burst. The block measures the time between crossings. When the spacing it sees cannot belong to a healthy mains line, it drops the carrier at once and reports the fault. All timing counts a 1 us tick input, and a parameter holds the half-cycle length: 8333 us for 60 Hz, or 10000 us for 50 Hz.

Top module: `mains_cmd_tx`

## Requirements
- R1: `cmd_ready` is high only while the block is idle. After a command is accepted it stays low until the cycle in which `tx_done` or `tx_error` pulses.
- R2: A command with house code 16 or above or key code 32 or above is refused. In the cycle after acceptance, `tx_error` pulses with `error_kind` = 1, and the carrier stays off.
- R3: A crossing locks the block only if more than SYNC_MIN_US ticks have passed since the wait began. A crossing that comes earlier counts as a missed attempt, and so does a wait with no crossing for 30 half-cycles. After SYNC_TRIES missed attempts, `tx_error` pulses with `error_kind` = 2 and no burst is sent.
- R4: After the locking crossing, the carrier stays off for five crossings. The sixth crossing opens the first slot of the first frame.
- R5: A frame is 22 slots, sent in this order: the start slots 1,1,1,0; then the four house bits; then the five key bits. Each code bit is sent as the bit itself followed by its inverse.
- R6: House index i is coded as the four bits (sent first to last) i[0], ~(i[1]^i[2]), ~i[2], i[2]^i[3]. This gives A(0)=0110, B(1)=1110, C(2)=0010, M(12)=0000 and P(15)=1100. A key below 16 uses the house coding of its low four bits followed by 0. A key of 16 to 31 sends its low four bits in binary, most significant first, followed by 1.
- R7: A slot holding 1 raises `carrier_en` on the clock edge that first samples the new `zc_sync` level and holds it for exactly BURST_US ticks. A slot holding 0 leaves the carrier off.
- R8: The frame is sent back to back as many times as the repeat count gives. A repeat count of 0 sends it once.
- R9: After each burst period, the next crossing must come at least 72% and at most 102% of a half-cycle later. During the idle crossings the same window is measured from crossing to crossing. A crossing that comes too early, or a wait that runs too long, ends the command with `tx_error`, `error_kind` = 3 and the carrier off in that same cycle.
- R10: `tx_done` pulses once, at the crossing that closes the last slot. `tx_done` and `tx_error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| zc_sync | input | 1 | Mains phase level, already synchronised; each change is a zero crossing |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_house | input | 8 | House code index |
| cmd_key | input | 8 | Key code index |
| cmd_reps | input | 8 | Number of frame copies |
| carrier_en | output | 1 | Carrier burst enable to the modem |
| tx_done | output | 1 | One-cycle pulse: command sent |
| tx_error | output | 1 | One-cycle pulse: command ended with a fault |
| error_kind | output | 2 | Fault kind, valid with `tx_error`: 1 bad command, 2 no lock, 3 framing |

## Verification
The bench aims at the sync boundary. A command accepted a few ticks before a crossing must skip that crossing. A design that locked on it would start every frame one slot early. Random house and key codes are decoded from the carrier one slot at a time and compared with a bench coding table, so a wrong letter coding or a missing inverse half shows up as a frame miscompare. Repeat counts of 0 and 2 catch a design that sends nothing or leaves a gap between copies. Crossings that come early, crossings that stop, and a stuck phase input must each give their own error kind with the carrier already dropped. A design that kept bursting after such a fault would fail those checks.

// File: rtl/mains_tx_pkg.sv
package mains_tx_pkg;

    localparam int HOUSE_W       = 4;
    localparam int KEY_W         = 5;
    localparam int CODE_W        = HOUSE_W + KEY_W;
    localparam int START_SLOTS   = 4;
    localparam int FRAME_SLOTS   = START_SLOTS + 2 * CODE_W;
    localparam int GAP_CROSSINGS = 6;

    localparam logic [START_SLOTS-1:0] START_PAT = 4'b1110;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_GAP,
        ST_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        FAIL_NONE  = 2'd0,
        FAIL_CMD   = 2'd1,
        FAIL_SYNC  = 2'd2,
        FAIL_FRAME = 2'd3
    } fail_e;

    // Letter coding, first-sent bit in the MSB position.
    function automatic logic [HOUSE_W-1:0] letter_bits(input logic [HOUSE_W-1:0] idx);
        return {idx[0], ~(idx[1] ^ idx[2]), ~idx[2], idx[2] ^ idx[3]};
    endfunction

endpackage

// File: rtl/mains_zc_edge.sv
module mains_zc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_in,
    output logic xing
);
    logic zc_q, primed_q;

    // The first cycle after reset only captures the level.
    assign xing = primed_q & (zc_in ^ zc_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_q     <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            zc_q     <= zc_in;
            primed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mains_tick_timer.sv
module mains_tick_timer #(
    parameter  int LIMIT = 1000,
    localparam int W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (tick && cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/mains_frame_build.sv
module mains_frame_build
    import mains_tx_pkg::*;
(
    input  logic [HOUSE_W-1:0]     house,
    input  logic [KEY_W-1:0]       key,
    output logic [FRAME_SLOTS-1:0] slots
);
    logic [KEY_W-1:0]  key_bits;
    logic [CODE_W-1:0] code;

    assign key_bits = key[KEY_W-1] ? {key[KEY_W-2:0], 1'b1}
                                   : {letter_bits(key[KEY_W-2:0]), 1'b0};
    assign code     = {letter_bits(house), key_bits};

    assign slots[FRAME_SLOTS-1 -: START_SLOTS] = START_PAT;

    // Each code bit takes a true slot followed by an inverted slot.
    for (genvar j = 0; j < CODE_W; j++) begin : g_pair
        assign slots[2*j+1] = code[j];
        assign slots[2*j]   = ~code[j];
    end
endmodule

// File: rtl/mains_cmd_tx.sv
module mains_cmd_tx
    import mains_tx_pkg::*;
#(
    parameter int HALF_US     = 8333,
    parameter int BURST_US    = 1000,
    parameter int SYNC_MIN_US = 100,
    parameter int SYNC_TRIES  = 10,
    parameter int CMD_W       = 8,
    parameter int REP_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic             zc_sync,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CMD_W-1:0] cmd_house,
    input  logic [CMD_W-1:0] cmd_key,
    input  logic [REP_W-1:0] cmd_reps,
    output logic             carrier_en,
    output logic             tx_done,
    output logic             tx_error,
    output logic [1:0]       error_kind
);
    localparam int GAP_MIN_US      = HALF_US * 72 / 100;
    localparam int GAP_MAX_US      = HALF_US * 102 / 100;
    localparam int SYNC_TIMEOUT_US = HALF_US * 30;
    localparam int TMAX            = SYNC_TIMEOUT_US + GAP_MAX_US + BURST_US;
    localparam int CW              = $clog2(TMAX + 1);
    localparam int TW              = $clog2(SYNC_TRIES + 1);
    localparam int GW              = $clog2(GAP_CROSSINGS + 1);
    localparam int SW              = $clog2(FRAME_SLOTS);

    localparam logic [CW-1:0]    SYNC_MIN_C  = CW'(SYNC_MIN_US);
    localparam logic [CW-1:0]    SYNC_LAST_C = CW'(SYNC_TIMEOUT_US - 1);
    localparam logic [CW-1:0]    BURST_LAST  = CW'(BURST_US - 1);
    localparam logic [CW-1:0]    GAP_MIN_C   = CW'(GAP_MIN_US);
    localparam logic [CW-1:0]    GAP_MAX_C   = CW'(GAP_MAX_US);
    localparam logic [TW-1:0]    TRIES_LAST  = TW'(SYNC_TRIES - 1);
    localparam logic [GW-1:0]    GAP_LAST    = GW'(GAP_CROSSINGS - 1);
    localparam logic [SW-1:0]    SLOT_LAST   = SW'(FRAME_SLOTS - 1);
    localparam logic [CMD_W-1:0] HOUSE_LIM   = CMD_W'(1 << HOUSE_W);
    localparam logic [CMD_W-1:0] KEY_LIM     = CMD_W'(1 << KEY_W);
    localparam logic [REP_W-1:0] ONE_REP     = REP_W'(1);

    typedef struct packed {
        tx_state_e              st;
        logic [TW-1:0]          tries;
        logic [GW-1:0]          gaps;
        logic [SW-1:0]          slot;
        logic [REP_W-1:0]       reps;
        logic [FRAME_SLOTS-1:0] frame;
        logic [FRAME_SLOTS-1:0] sh;
        logic                   burst;
        logic                   carrier;
        logic                   done;
        logic                   err;
        fail_e                  code;
    } tx_regs_t;

    tx_regs_t               r_q, r_d;
    logic                   zc_edge;
    logic                   tclr;
    logic                   sync_miss;
    logic                   frame_fail;
    logic [CW-1:0]          tcnt;
    logic [FRAME_SLOTS-1:0] frame_w;

    mains_zc_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .zc_in (zc_sync),
        .xing  (zc_edge)
    );

    mains_tick_timer #(.LIMIT(TMAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_us),
        .clear (tclr),
        .count (tcnt)
    );

    mains_frame_build u_build (
        .house (cmd_house[HOUSE_W-1:0]),
        .key   (cmd_key[KEY_W-1:0]),
        .slots (frame_w)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        tclr       = 1'b0;
        sync_miss  = 1'b0;
        frame_fail = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.code = FAIL_NONE;
                    if (cmd_house >= HOUSE_LIM || cmd_key >= KEY_LIM) begin
                        r_d.err  = 1'b1;
                        r_d.code = FAIL_CMD;
                    end else begin
                        r_d.st    = ST_SYNC;
                        r_d.frame = frame_w;
                        r_d.reps  = (cmd_reps == '0) ? ONE_REP : cmd_reps;
                        r_d.tries = '0;
                        tclr      = 1'b1;
                    end
                end
            end

            ST_SYNC: begin
                if (zc_edge) begin
                    tclr = 1'b1;
                    if (tcnt > SYNC_MIN_C) begin
                        r_d.st   = ST_GAP;
                        r_d.gaps = '0;
                    end else begin
                        sync_miss = 1'b1;
                    end
                end else if (tick_us && tcnt == SYNC_LAST_C) begin
                    tclr      = 1'b1;
                    sync_miss = 1'b1;
                end
                if (sync_miss) begin
                    if (r_q.tries == TRIES_LAST) begin
                        r_d.st   = ST_IDLE;
                        r_d.err  = 1'b1;
                        r_d.code = FAIL_SYNC;
                    end else begin
                        r_d.tries = r_q.tries + 1'b1;
                    end
                end
            end

            ST_GAP: begin
                if (zc_edge) begin
                    if (tcnt < GAP_MIN_C) begin
                        frame_fail = 1'b1;
                    end else begin
                        tclr = 1'b1;
                        if (r_q.gaps == GAP_LAST) begin
                            r_d.st      = ST_SEND;
                            r_d.slot    = '0;
                            r_d.sh      = r_q.frame;
                            r_d.burst   = 1'b1;
                            r_d.carrier = r_q.frame[FRAME_SLOTS-1];
                        end else begin
                            r_d.gaps = r_q.gaps + 1'b1;
                        end
                    end
                end else if (tick_us && tcnt == GAP_MAX_C) begin
                    frame_fail = 1'b1;
                end
            end

            ST_SEND: begin
                if (r_q.burst) begin
                    if (zc_edge) begin
                        frame_fail = 1'b1;
                    end else if (tick_us && tcnt == BURST_LAST) begin
                        r_d.burst   = 1'b0;
                        r_d.carrier = 1'b0;
                        tclr        = 1'b1;
                    end
                end else if (zc_edge) begin
                    if (tcnt < GAP_MIN_C) begin
                        frame_fail = 1'b1;
                    end else begin
                        tclr = 1'b1;
                        if (r_q.slot == SLOT_LAST) begin
                            if (r_q.reps == ONE_REP) begin
                                r_d.st   = ST_IDLE;
                                r_d.done = 1'b1;
                            end else begin
                                r_d.reps    = r_q.reps - 1'b1;
                                r_d.slot    = '0;
                                r_d.sh      = r_q.frame;
                                r_d.burst   = 1'b1;
                                r_d.carrier = r_q.frame[FRAME_SLOTS-1];
                            end
                        end else begin
                            r_d.slot    = r_q.slot + 1'b1;
                            r_d.sh      = {r_q.sh[FRAME_SLOTS-2:0], 1'b0};
                            r_d.burst   = 1'b1;
                            r_d.carrier = r_q.sh[FRAME_SLOTS-2];
                        end
                    end
                end else if (tick_us && tcnt == GAP_MAX_C) begin
                    frame_fail = 1'b1;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase

        if (frame_fail) begin
            r_d.st      = ST_IDLE;
            r_d.burst   = 1'b0;
            r_d.carrier = 1'b0;
            r_d.err     = 1'b1;
            r_d.code    = FAIL_FRAME;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.code <= FAIL_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready  = (r_q.st == ST_IDLE);
    assign carrier_en = r_q.carrier;
    assign tx_done    = r_q.done;
    assign tx_error   = r_q.err;
    assign error_kind = r_q.code;

    // Accepting a command drops ready unless it is refused at once.
    assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_ready || tx_error));

    // No carrier while idle, so a refused command never bursts.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !carrier_en);

    // A burst only starts on a sampled zero crossing.
    assert_rise_on_xing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_en) |-> $past(zc_edge));

    // A fault report always comes with the carrier already off.
    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_error |-> !carrier_en);

    // One outcome per command.
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_error));

endmodule

// File: tb/mains_cmd_tx_tb.sv
module mains_cmd_tx_tb;
    localparam int HALF  = 64;
    localparam int BURST = 8;
    localparam int SLOTS = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       zc_sync = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_house = '0, cmd_key = '0, cmd_reps = '0;
    logic       cmd_ready, carrier_en, tx_done, tx_error;
    logic [1:0] error_kind;

    mains_cmd_tx #(.HALF_US(HALF), .BURST_US(BURST), .SYNC_MIN_US(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .zc_sync(zc_sync),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_house(cmd_house),
        .cmd_key(cmd_key), .cmd_reps(cmd_reps), .carrier_en(carrier_en),
        .tx_done(tx_done), .tx_error(tx_error), .error_kind(error_kind)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_fail = 0;

    // Mains model and output monitor, all on the falling edge.
    int  half = HALF;
    bit  zc_run = 1'b0;
    int  ph = 0, age = 0, tog_cnt = 0;
    bit  cap [0:255];
    int  cap_n = 0, rises = 0, first_rise = -1, bad_rise = 0, bad_run = 0, run = 0;
    int  n_done = 0, n_err = 0, last_kind = 0;
    bit  car_at_err = 1'b0, car_prev = 1'b0;

    always @(negedge clk) begin
        if (carrier_en && !car_prev) begin
            rises++;
            if (age != 0) bad_rise++;
            if (first_rise < 0) first_rise = tog_cnt;
        end
        if (carrier_en) run++;
        else if (car_prev) begin
            if (run != BURST) bad_run++;
            run = 0;
        end
        car_prev = carrier_en;
        if (age == 1 && !cmd_ready && cap_n < 256) begin
            cap[cap_n] = carrier_en;
            cap_n++;
        end
        if (tx_done) n_done++;
        if (tx_error) begin
            n_err++;
            last_kind  = int'(error_kind);
            car_at_err = carrier_en;
        end
        if (zc_run && ph + 1 >= half) begin
            zc_sync = ~zc_sync;
            ph = 0;
            age = 0;
            tog_cnt++;
        end else begin
            if (zc_run) ph++;
            age++;
        end
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 190000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Bench coding table for letters A..P.
    logic [3:0] HT [16] = '{4'b0110, 4'b1110, 4'b0010, 4'b1010, 4'b0001, 4'b1001,
                            4'b0101, 4'b1101, 4'b0111, 4'b1111, 4'b0011, 4'b1011,
                            4'b0000, 4'b1000, 4'b0100, 4'b1100};

    function automatic logic [21:0] exp_frame(input int h, input int k);
        logic [8:0]  c;
        logic [4:0]  kk;
        logic [21:0] f;
        kk = k[4:0];
        c[8:5] = HT[h];
        c[4:0] = (k < 16) ? {HT[k], 1'b0} : {kk[3:0], 1'b1};
        f[21:18] = 4'b1110;
        for (int j = 0; j < 9; j++) begin
            f[17-2*j] = c[8-j];
            f[16-2*j] = ~c[8-j];
        end
        return f;
    endfunction

    int acc_tog = 0;

    task automatic issue(input int h, input int k, input int r, input int off);
        if (off >= 0) begin
            do @(posedge clk); while (age != off);
        end else @(posedge clk);
        cap_n = 0; rises = 0; first_rise = -1; bad_rise = 0; bad_run = 0;
        @(negedge clk);
        cmd_house = 8'(h); cmd_key = 8'(k); cmd_reps = 8'(r); cmd_valid = 1'b1;
        @(posedge clk);
        acc_tog = tog_cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_outcome(input int d0, input int e0);
        while (n_done == d0 && n_err == e0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic run_ok(input int h, input int k, input int r, input int off, input int lead);
        int d0, e0, nrep, ones;
        logic [21:0] f, got;
        f = exp_frame(h, k);
        nrep = (r == 0) ? 1 : r;
        d0 = n_done; e0 = n_err;
        issue(h, k, r, off);
        check(!cmd_ready, "R1 ready low after accept", longint'(cmd_ready), 0);
        wait_outcome(d0, e0);
        check(n_done == d0 + 1 && n_err == e0, "R10 single done", n_done - d0, 1);
        check(cmd_ready, "R1 ready back", longint'(cmd_ready), 1);
        check(first_rise - acc_tog == lead, "R4 R3 first burst crossing",
              first_rise - acc_tog, lead);
        for (int p = 0; p < nrep; p++) begin
            for (int i = 0; i < SLOTS; i++)
                got[21-i] = (cap_n >= nrep * SLOTS) ? cap[cap_n - nrep*SLOTS + p*SLOTS + i] : 1'b0;
            check(got == f, "R5 R6 frame slots", got, f);
        end
        ones = $countones(f);
        check(rises == nrep * ones, "R8 bursts over repeats", rises, nrep * ones);
        check(bad_rise == 0 && bad_run == 0, "R7 burst timing", bad_rise + bad_run, 0);
    endtask

    task automatic run_err(input int h, input int k, input int kind, input int off, input string tag);
        int d0, e0;
        d0 = n_done; e0 = n_err;
        issue(h, k, 1, off);
        wait_outcome(d0, e0);
        check(n_err == e0 + 1 && n_done == d0, {tag, " error pulse"}, n_err - e0, 1);
        check(last_kind == kind, {tag, " error kind"}, last_kind, kind);
        check(rises == 0, {tag, " no burst"}, rises, 0);
        check(cmd_ready, {tag, " R1 ready back"}, longint'(cmd_ready), 1);
    endtask

    task automatic run_frame_err(input bit stop_mains);
        int d0, e0;
        d0 = n_done; e0 = n_err;
        issue(3, 18, 1, 20);
        while (rises == 0) @(posedge clk);
        if (stop_mains) zc_run = 1'b0;
        else            half = 30;
        wait_outcome(d0, e0);
        check(n_err == e0 + 1, "R9 framing error pulse", n_err - e0, 1);
        check(last_kind == 3, "R9 framing kind", last_kind, 3);
        check(!car_at_err && !carrier_en, "R9 carrier off", longint'(car_at_err), 0);
        zc_run = 1'b1;
        half = HALF;
        repeat (3 * HALF) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        check(cmd_ready && !carrier_en && !tx_done && !tx_error, "R1 reset state",
              {cmd_ready, carrier_en, tx_done, tx_error}, 4'b1000);
        rst_n = 1'b1;
        zc_run = 1'b1;
        repeat (2 * HALF) @(posedge clk);

        // R2: refused codes
        run_err(16, 3, 1, 20, "R2 house 16");
        run_err(2, 40, 1, 20, "R2 key 40");

        // Directed frames
        run_ok(0, 0, 1, 20, 7);     // A, unit 1
        run_ok(15, 31, 2, 20, 7);   // P, last function, two copies
        run_ok(12, 16, 0, 20, 7);   // M, repeat 0 sends once (R8)
        run_ok(1, 28, 1, 20, 7);    // B, key 28

        // R3: crossing right after accept is skipped
        run_ok(2, 5, 1, 56, 8);

        // Random commands
        for (int n = 0; n < 5; n++)
            run_ok(int'($urandom % 16), int'($urandom % 32), int'(1 + $urandom % 2), 20, 7);

        // R9: early crossing, then missing crossing
        run_frame_err(1'b0);
        run_frame_err(1'b1);

        // R3: stuck mains, no lock
        zc_run = 1'b0;
        run_err(4, 4, 2, -1, "R3 no lock");
        zc_run = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule